// File: doc/BRIEF.md
# Oversampled Asynchronous Serial Receiver

This block recovers characters from a single asynchronous serial line. It uses a one-cycle tick at sixteen times the bit rate to find the start bit, confirm it in mid-bit, and take one sample in the centre of every later bit. The first bit sampled lands in bit 0 of the received word. Between five and eight data bits are kept, and the high bits that are not used stay at zero. An optional parity bit is checked and then dropped. The stop bit is checked for a framing fault.

A completed character goes into a holding register and raises a "data ready" flag. The same event sets framing-error and parity-error flags that describe that character. If a character completes while the previous one has not been read, an overrun flag is set and the older data is kept. A single read strobe takes the character and clears the ready flag and all three error flags. A select input chooses the sixteen-times tick. It can come from the local rate generator or from an external clock enable, which is then divided by sixteen per bit.

Top module: `asyncRx`

## Requirements
- R1: A start bit is detected at a tick on which `rxIn` is low and was high at the previous tick. It is confirmed by sampling `rxIn` low on the 8th tick after detection. The line is then sampled every 16 ticks: data bits, then the parity bit if enabled, then one stop bit.
- R2: `wordLen` selects the character length: 0 selects 5 bits, 1 selects 6, 2 selects 7 and 3 selects 8. The first data bit goes to `rxData[0]`, and bits above the character length read as 0.
- R3: With `parEn`=1 a parity bit follows the data. `parOdd`=0 expects an even count of ones over data and parity, and `parOdd`=1 expects an odd count. A mismatch sets `parErr`. The parity bit never appears in `rxData`.
- R4: `frameErr` is set for a character whose stop bit is sampled low.
- R5: When the stop bit is sampled and no unread character is held, the character loads into `rxData` and `rxFull` goes to 1 on the next cycle.
- R6: If a character completes while `rxFull` is 1 and no read occurs in that cycle, `overrun` is set. `rxData`, `frameErr` and `parErr` keep their previous values.
- R7: `rdStb` clears `rxFull`, `frameErr`, `parErr` and `overrun` on the next cycle. A character completing in the same cycle as a read is loaded as if the register were empty.
- R8: `srcExt`=0 uses `baudTick` as the sixteen-times tick and `srcExt`=1 uses `extTick`. The unselected tick has no effect.
- R9: If `rxIn` is high at the 8th-tick confirmation, the start is discarded and no character is produced.
- R10: After reset `rxData` is 0 and `rxFull`, `frameErr`, `parErr` and `overrun` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxIn | input | 1 | Serial line, already synchronous to clk, idle high |
| baudTick | input | 1 | Sixteen-times tick from the local rate generator |
| extTick | input | 1 | Sixteen-times tick from the external clock |
| srcExt | input | 1 | 1 selects extTick, 0 selects baudTick |
| wordLen | input | 2 | Character length code (5 + value bits) |
| parEn | input | 1 | Parity bit present and checked |
| parOdd | input | 1 | 1 = odd parity, 0 = even parity |
| rdStb | input | 1 | Read of the received character, one cycle |
| rxData | output | 8 | Received character, zero-filled |
| rxFull | output | 1 | Unread character held |
| frameErr | output | 1 | Stop bit of the held character was low |
| parErr | output | 1 | Parity of the held character was wrong |
| overrun | output | 1 | A character was lost while the register was full |

## Verification
The bench sends 5-bit characters with all ones, so a receiver that fails to zero-fill, or that stores the parity bit as a data bit, returns a wrong value. It flips a parity bit and drops a stop bit, so swapped or missing error logic leaves a flag in the wrong state. It sends two characters with no read between them, so a design that overwrites on overrun returns the second character. It also sends a short low glitch and a character clocked only by the unselected tick. A receiver that skips the mid-bit confirmation, or that ignores the source select, would then report a character that never arrived.

// File: rtl/asyncRxPkg.sv
package asyncRxPkg;
  localparam int RX_DW = 8;
  localparam int IDX_W = $clog2(RX_DW);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rxState_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic             clr;
    logic             dataSmp;
    logic [IDX_W-1:0] idx;
    logic             parSmp;
    logic             done;
  } rxStb_t;

  // Index of the final data bit for a length code (0 -> 5 bits)
  function automatic logic [IDX_W-1:0] lastIdx(input logic [1:0] wl);
    return IDX_W'(4 + int'(wl));
  endfunction
endpackage

// File: rtl/asyncRxCtrl.sv
module asyncRxCtrl
  import asyncRxPkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       rxIn,
  input  logic [1:0] wordLen,
  input  logic       parEn,
  output rxStb_t     stb
);
  localparam int CW = $clog2(OVS);
  localparam logic [CW-1:0] CNT_LAST = CW'(OVS - 1);
  localparam logic [CW-1:0] CNT_HALF = CW'(OVS / 2 - 1);

  rxState_e         state;
  logic [CW-1:0]    cnt;
  logic [IDX_W-1:0] idx;
  logic             lastRx;
  logic             atLast;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      idx    <= '0;
      lastRx <= 1'b1;
    end else if (tick) begin
      lastRx <= rxIn;
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (lastRx && !rxIn) state <= ST_START;
        end
        ST_START: begin
          if (cnt == CNT_HALF) begin
            cnt   <= '0;
            idx   <= '0;
            state <= rxIn ? ST_IDLE : ST_DATA;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DATA: begin
          if (cnt == CNT_LAST) begin
            cnt <= '0;
            if (idx == lastIdx(wordLen)) begin
              idx   <= '0;
              state <= parEn ? ST_PAR : ST_STOP;
            end else begin
              idx <= idx + 1'b1;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_PAR: begin
          if (cnt == CNT_LAST) begin
            cnt   <= '0;
            state <= ST_STOP;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_STOP: begin
          if (cnt == CNT_LAST) begin
            cnt   <= '0;
            state <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    atLast      = tick && (cnt == CNT_LAST);
    stb.clr     = tick && (state == ST_START) && (cnt == CNT_HALF) && !rxIn;
    stb.dataSmp = atLast && (state == ST_DATA);
    stb.idx     = idx;
    stb.parSmp  = atLast && (state == ST_PAR);
    stb.done    = atLast && (state == ST_STOP);
  end

  // R1: a confirmed start enters the data phase at bit 0
  p_start_to_data_r1: assert property (@(posedge clk) disable iff (!rstN)
    stb.clr |=> (state == ST_DATA) && (idx == '0));

  // R1: the stop sample returns the sequencer to idle
  p_done_to_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    stb.done |=> (state == ST_IDLE));

  // R9: a high line at confirmation abandons the start
  p_false_start_r9: assert property (@(posedge clk) disable iff (!rstN)
    (tick && state == ST_START && cnt == CNT_HALF && rxIn) |=> (state == ST_IDLE));
endmodule

// File: rtl/asyncRxData.sv
module asyncRxData
  import asyncRxPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxIn,
  input  rxStb_t           stb,
  input  logic [1:0]       wordLen,
  input  logic             parEn,
  input  logic             parOdd,
  input  logic             rdStb,
  output logic [RX_DW-1:0] rxData,
  output logic             rxFull,
  output logic             frameErr,
  output logic             parErr,
  output logic             overrun
);
  logic [RX_DW-1:0] shReg;
  logic             acc;
  logic             heldFull;

  assign heldFull = rxFull && !rdStb;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg <= '0;
      acc   <= 1'b0;
    end else if (stb.clr) begin
      shReg <= '0;
      acc   <= 1'b0;
    end else if (stb.dataSmp) begin
      shReg[stb.idx] <= rxIn;
      acc            <= acc ^ rxIn;
    end else if (stb.parSmp) begin
      acc <= acc ^ rxIn;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxData   <= '0;
      rxFull   <= 1'b0;
      frameErr <= 1'b0;
      parErr   <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      if (rdStb) begin
        rxFull   <= 1'b0;
        frameErr <= 1'b0;
        parErr   <= 1'b0;
        overrun  <= 1'b0;
      end
      if (stb.done) begin
        if (heldFull) begin
          overrun <= 1'b1;
        end else begin
          rxData   <= shReg;
          rxFull   <= 1'b1;
          frameErr <= !rxIn;
          parErr   <= parEn && (acc ^ parOdd);
        end
      end
    end
  end

  // R2: a freshly loaded character has no bits above its length
  p_unused_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxFull) |-> ((rxData >> (5 + int'(wordLen))) == '0));

  // R6: overrun keeps the held character
  p_overrun_keeps_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.done && rxFull && !rdStb) |=> (overrun && $stable(rxData)));

  // R6: overrun is only raised over a full register
  p_overrun_full_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overrun) |-> $past(rxFull));

  // R7: a read with no completion clears every flag
  p_read_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && !stb.done) |=> (!rxFull && !overrun && !frameErr && !parErr));
endmodule

// File: rtl/asyncRx.sv
module asyncRx
  import asyncRxPkg::*;
#(
  parameter int OVS = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rxIn,
  input  logic             baudTick,
  input  logic             extTick,
  input  logic             srcExt,
  input  logic [1:0]       wordLen,
  input  logic             parEn,
  input  logic             parOdd,
  input  logic             rdStb,
  output logic [RX_DW-1:0] rxData,
  output logic             rxFull,
  output logic             frameErr,
  output logic             parErr,
  output logic             overrun
);
  logic   tick;
  rxStb_t stb;

  // R8: sixteen-times tick source select
  assign tick = srcExt ? extTick : baudTick;

  asyncRxCtrl #(.OVS(OVS)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .tick    (tick),
    .rxIn    (rxIn),
    .wordLen (wordLen),
    .parEn   (parEn),
    .stb     (stb)
  );

  asyncRxData u_data (
    .clk      (clk),
    .rstN     (rstN),
    .rxIn     (rxIn),
    .stb      (stb),
    .wordLen  (wordLen),
    .parEn    (parEn),
    .parOdd   (parOdd),
    .rdStb    (rdStb),
    .rxData   (rxData),
    .rxFull   (rxFull),
    .frameErr (frameErr),
    .parErr   (parErr),
    .overrun  (overrun)
  );
endmodule

// File: tb/asyncRx_bench.sv
`timescale 1ns/1ps
module asyncRx_bench;
  localparam int BAUD_P = 4;
  localparam int EXT_P  = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rxIn = 1'b1;
  logic       baudTick = 1'b0;
  logic       extTick = 1'b0;
  logic       srcExt = 1'b0;
  logic [1:0] wordLen = 2'd3;
  logic       parEn = 1'b0;
  logic       parOdd = 1'b0;
  logic       rdStb = 1'b0;
  logic [7:0] rxData;
  logic       rxFull, frameErr, parErr, overrun;

  int  checks = 0;
  int  errors = 0;
  int  cycles = 0;
  bit  baudOn = 1'b1;
  bit  doneAll = 1'b0;
  int  baudCnt = 0;
  int  extCnt = 0;

  always #2 clk = ~clk;

  asyncRx u_asyncRx (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .baudTick(baudTick), .extTick(extTick),
    .srcExt(srcExt), .wordLen(wordLen), .parEn(parEn), .parOdd(parOdd),
    .rdStb(rdStb), .rxData(rxData), .rxFull(rxFull), .frameErr(frameErr),
    .parErr(parErr), .overrun(overrun)
  );

  // Tick generators, driven away from the active edge
  always @(negedge clk) begin
    baudCnt  = (baudCnt + 1) % BAUD_P;
    extCnt   = (extCnt + 1) % EXT_P;
    baudTick = baudOn && (baudCnt == 0);
    extTick  = (extCnt == 0);
  end

  // Behavioural reference model
  int       mPhase, mTicks, mBits, mOnes;
  bit       mLast, mFull, mFe, mPe, mOv;
  bit [7:0] mWord, mData;

  always @(posedge clk) begin
    bit tk;
    if (!rstN) begin
      mPhase = 0; mTicks = 0; mBits = 0; mOnes = 0; mLast = 1;
      mFull = 0; mFe = 0; mPe = 0; mOv = 0; mWord = 0; mData = 0;
    end else begin
      tk = srcExt ? extTick : baudTick;
      if (rdStb) begin mFull = 0; mFe = 0; mPe = 0; mOv = 0; end
      if (tk) begin
        case (mPhase)
          0: if (mLast && !rxIn) begin mPhase = 1; mTicks = 0; end
          1: begin
            mTicks++;
            if (mTicks == 8) begin
              if (!rxIn) begin mPhase = 2; mBits = 0; mWord = 0; mOnes = 0; end
              else mPhase = 0;
              mTicks = 0;
            end
          end
          2: begin
            mTicks++;
            if (mTicks == 16) begin
              mTicks = 0;
              if (rxIn) begin mWord[mBits] = 1'b1; mOnes++; end
              mBits++;
              if (mBits == 5 + int'(wordLen)) mPhase = parEn ? 3 : 4;
            end
          end
          3: begin
            mTicks++;
            if (mTicks == 16) begin mTicks = 0; if (rxIn) mOnes++; mPhase = 4; end
          end
          default: begin
            mTicks++;
            if (mTicks == 16) begin
              mTicks = 0; mPhase = 0;
              if (mFull) mOv = 1;
              else begin
                mData = mWord; mFull = 1; mFe = !rxIn;
                mPe = parEn && ((mOnes % 2) != int'(parOdd));
              end
            end
          end
        endcase
        mLast = rxIn;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare against the model on every clock
  always @(negedge clk) begin
    if (rstN && !doneAll) begin
      chk("R2 rxData model", {24'd0, rxData}, {24'd0, mData});
      chk("R5 rxFull model", {31'd0, rxFull}, {31'd0, mFull});
      chk("R4 frameErr model", {31'd0, frameErr}, {31'd0, mFe});
      chk("R3 parErr model", {31'd0, parErr}, {31'd0, mPe});
      chk("R6 overrun model", {31'd0, overrun}, {31'd0, mOv});
    end
  end

  task automatic sendChar(input logic [7:0] d, input int nb, input int p,
                          input bit flipPar, input bit badStop);
    int bt = 16 * p;
    bit par = 1'b0;
    rxIn = 1'b0; repeat (bt) @(negedge clk);
    for (int i = 0; i < nb; i++) begin
      rxIn = d[i]; par ^= d[i]; repeat (bt) @(negedge clk);
    end
    if (parEn) begin
      rxIn = par ^ parOdd ^ flipPar; repeat (bt) @(negedge clk);
    end
    rxIn = !badStop; repeat (bt) @(negedge clk);
    rxIn = 1'b1; repeat (bt) @(negedge clk);
  endtask

  task automatic readReg();
    rdStb = 1'b1; @(negedge clk);
    rdStb = 1'b0; @(negedge clk);
  endtask

  task automatic finishRun();
    doneAll = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !doneAll) begin
      checks++; errors++;
      $display("FAIL R1 watchdog actual=%0d expected=<150000", cycles);
      finishRun();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 rxData", {24'd0, rxData}, 0);
    chk("R10 flags", {28'd0, rxFull, frameErr, parErr, overrun}, 0);

    // R1 R5: 8 data bits, no parity
    wordLen = 2'd3; parEn = 0;
    sendChar(8'hA5, 8, BAUD_P, 0, 0);
    chk("R1 data 8N1", {24'd0, rxData}, 32'hA5);
    chk("R5 full set", {31'd0, rxFull}, 1);
    chk("R4 no frame err", {31'd0, frameErr}, 0);
    readReg();
    chk("R7 full cleared", {31'd0, rxFull}, 0);

    // R2 R3: 5 bits, even parity, zero fill
    wordLen = 2'd0; parEn = 1; parOdd = 0;
    sendChar(8'hFF, 5, BAUD_P, 0, 0);
    chk("R2 5-bit zero fill", {24'd0, rxData}, 32'h1F);
    chk("R3 even parity ok", {31'd0, parErr}, 0);
    readReg();

    // R3: 7 bits, odd parity, parity bit not stored
    wordLen = 2'd2; parOdd = 1;
    sendChar(8'h55, 7, BAUD_P, 0, 0);
    chk("R3 7-bit odd data", {24'd0, rxData}, 32'h55);
    chk("R3 odd parity ok", {31'd0, parErr}, 0);
    readReg();
    sendChar(8'h7F, 7, BAUD_P, 1, 0);
    chk("R3 bad parity flagged", {31'd0, parErr}, 1);
    chk("R3 data without parity", {24'd0, rxData}, 32'h7F);
    readReg();
    chk("R7 parErr cleared", {31'd0, parErr}, 0);

    // R4: stop bit low
    wordLen = 2'd3; parEn = 0;
    sendChar(8'h3C, 8, BAUD_P, 0, 1);
    chk("R4 frame err", {31'd0, frameErr}, 1);
    chk("R4 data", {24'd0, rxData}, 32'h3C);
    readReg();
    chk("R7 frameErr cleared", {31'd0, frameErr}, 0);

    // R6: overrun, 6 bits
    wordLen = 2'd1;
    sendChar(8'h2A, 6, BAUD_P, 0, 0);
    sendChar(8'h15, 6, BAUD_P, 0, 0);
    chk("R6 overrun set", {31'd0, overrun}, 1);
    chk("R6 old data kept", {24'd0, rxData}, 32'h2A);
    readReg();
    chk("R7 all cleared", {28'd0, rxFull, frameErr, parErr, overrun}, 0);

    // R9: short glitch
    wordLen = 2'd3;
    rxIn = 1'b0; repeat (3 * BAUD_P) @(negedge clk);
    rxIn = 1'b1; repeat (40 * BAUD_P) @(negedge clk);
    chk("R9 glitch ignored", {31'd0, rxFull}, 0);

    // R8: external tick source
    srcExt = 1; baudOn = 0;
    sendChar(8'h81, 8, EXT_P, 0, 0);
    chk("R8 external source data", {24'd0, rxData}, 32'h81);
    chk("R8 external source full", {31'd0, rxFull}, 1);
    readReg();

    // R8: unselected tick has no effect
    srcExt = 0;
    sendChar(8'h7E, 8, EXT_P, 0, 0);
    chk("R8 unselected tick ignored", {31'd0, rxFull}, 0);
    chk("R8 data unchanged", {24'd0, rxData}, 32'h81);

    finishRun();
  end
endmodule